// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer attached to a small register bus. Software writes a load value, starts the timer with a two-word unlock sequence and then keeps writing a trigger register. Each trigger write copies the load value back into an up-counter. If software stops writing the trigger, the counter runs past its all-ones value. The block then emits a single-cycle reset pulse and reloads itself from the load value.

The counter advances on a slow `tick` input, which stands in for a 32 kHz clock enable. An optional power-of-two prescaler can sit in that path. Starting and stopping each need a matching pair of key words, written one after the other.

Every writable timer register carries a busy flag. The flag models the delay of carrying a write into the slow domain. While it is set, further writes to that register are dropped. Software polls the flags through a status register.

The bus has no handshake. A write completes in the cycle `bus_we` is high. Read data is combinational from `bus_addr`. Nothing streams through the block, so there is no valid/ready interface and no back-pressure.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the timer is stopped (key register bit 0 reads 0). The counter, load, control and busy status registers all read 0. Register word addresses are: control 0, load 1, counter 2, trigger 3, key 4, busy status 5, interface config 6.
- R2: Writing 0xBBBB and then 0x4444 to the key register (low 16 bits) sets the running state, which reads back as key register bit 0 = 1.
- R3: Writing 0xAAAA and then 0x5555 to the key register stops the timer. Key bit 0 then reads 0, and the counter holds its value.
- R4: After a first key word, a second key write that is not its partner abandons the sequence and leaves the running state unchanged. A partner word written with no first word before it has no effect.
- R5: An accepted write to the trigger register loads the counter with the load register value and clears the prescaler phase.
- R6: While running with the prescaler off (control bit 5 = 0), the counter advances by one on each tick. With it on, the counter advances once every 2^P ticks, where P is control bits 4:2.
- R7: While running, a tick that advances the counter from all ones raises `wdt_reset` for exactly one clock. In the same step the counter is loaded from the load register.
- R8: Busy status bits 0, 2, 3 and 4 belong to control, load, trigger and key. Each bit is set by an accepted write to its register and clears after PEND_TICKS ticks (2 by default). A write to a register whose bit is set is ignored.
- R9: Control bits 5:2 and interface-config bit 0 read back as written. Other bits of those registers read 0.
- R10: While stopped, ticks do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-domain count enable, one clock wide |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdt_reset | output | 1 | One-cycle pulse on counter overflow |

## Verification
The assertions watch several rules on every cycle:
- The reset pulse is never longer than one cycle.
- The counter equals the earlier load value when the reset pulse appears.
- The counter never moves while the timer is stopped, unless a trigger write reloads it.
- A load write made while the load register is busy leaves it unchanged.
- The running state changes only right after the closing word of a key pair.

Other behaviour depends on a sequence of writes and ticks, so only the bench scenarios can show it:
- the exact prescaler rate;
- abandoned or orphaned key words;
- busy-flag timing in ticks;
- read-back of the configuration fields;
- the overflow reload value seen at the ports.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_LOAD = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT  = 3'd2;
  localparam logic [REG_AW-1:0] A_TRIG = 3'd3;
  localparam logic [REG_AW-1:0] A_KEY  = 3'd4;
  localparam logic [REG_AW-1:0] A_BUSY = 3'd5;
  localparam logic [REG_AW-1:0] A_IFC  = 3'd6;

  localparam logic [15:0] KEY_RUN1  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN2  = 16'h4444;
  localparam logic [15:0] KEY_HALT1 = 16'hAAAA;
  localparam logic [15:0] KEY_HALT2 = 16'h5555;

  // busy slots, in order: control, load, trigger, key
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_LOAD = 1;
  localparam int SLOT_TRIG = 2;
  localparam int SLOT_KEY  = 3;
  localparam int N_SLOTS   = 4;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_RUN_ARMED,
    KS_HALT_ARMED
  } key_state_e;
endpackage

// File: rtl/wdg_busy.sv
module wdg_busy #(
  parameter int NSLOT      = 4,
  parameter int PEND_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NSLOT-1:0] wr_hit,
  output logic [NSLOT-1:0] busy
);
  localparam int CW = $clog2(PEND_TICKS + 1);
  localparam logic [CW-1:0] START = CW'(PEND_TICKS);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [CW-1:0] left_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        left_q <= '0;
      end else if (wr_hit[g]) begin
        left_q <= START;
      end else if (tick && (left_q != '0)) begin
        left_q <= left_q - 1'b1;
      end
    end
    assign busy[g] = (left_q != '0);
  end
endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_word,
  output logic        running
);
  key_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= KS_IDLE;
      running <= 1'b0;
    end else if (key_wr) begin
      unique case (st_q)
        KS_IDLE: begin
          if (key_word == KEY_RUN1)       st_q <= KS_RUN_ARMED;
          else if (key_word == KEY_HALT1) st_q <= KS_HALT_ARMED;
          else                            st_q <= KS_IDLE;
        end
        KS_RUN_ARMED: begin
          st_q <= KS_IDLE;
          if (key_word == KEY_RUN2) running <= 1'b1;
        end
        KS_HALT_ARMED: begin
          st_q <= KS_IDLE;
          if (key_word == KEY_HALT2) running <= 1'b0;
        end
        default: st_q <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             running,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int PSC_W = (1 << PTV_W) - 1;

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_lim;
  logic             step;

  assign psc_lim = ~({PSC_W{1'b1}} << ptv);
  assign step    = tick && running && (!pre_en || (psc_q == psc_lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      psc_q <= '0;
      ovf   <= 1'b0;
    end else if (reload) begin
      cnt   <= load_val;
      psc_q <= '0;
      ovf   <= 1'b0;
    end else if (step) begin
      psc_q <= '0;
      if (&cnt) begin
        cnt <= load_val;
        ovf <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        ovf <= 1'b0;
      end
    end else begin
      ovf <= 1'b0;
      if (!running)                psc_q <= '0;
      else if (tick && pre_en)     psc_q <= psc_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int PTV_W      = 3,
  parameter int PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_reset
);
  localparam int PTV_LSB = 2;
  localparam int PRE_BIT = PTV_LSB + PTV_W;

  logic [N_SLOTS-1:0] hit, busy;
  logic [N_SLOTS-1:0] sel;
  logic               pre_en_q;
  logic [PTV_W-1:0]   ptv_q;
  logic [DATA_W-1:0]  load_q;
  logic [DATA_W-1:0]  cnt_q;
  logic               ifc_q;
  logic               run_q;
  logic [DATA_W-1:0]  busy_word;

  always_comb begin
    sel            = '0;
    sel[SLOT_CTRL] = (bus_addr == ADDR_W'(A_CTRL));
    sel[SLOT_LOAD] = (bus_addr == ADDR_W'(A_LOAD));
    sel[SLOT_TRIG] = (bus_addr == ADDR_W'(A_TRIG));
    sel[SLOT_KEY]  = (bus_addr == ADDR_W'(A_KEY));
  end

  assign hit = {N_SLOTS{bus_we}} & sel & ~busy;

  wdg_busy #(.NSLOT(N_SLOTS), .PEND_TICKS(PEND_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_hit(hit), .busy(busy)
  );

  wdg_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .key_wr(hit[SLOT_KEY]),
    .key_word(bus_wdata[15:0]), .running(run_q)
  );

  wdg_count #(.CNT_W(DATA_W), .PTV_W(PTV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(run_q),
    .pre_en(pre_en_q), .ptv(ptv_q), .reload(hit[SLOT_TRIG]),
    .load_val(load_q), .cnt(cnt_q), .ovf(wdt_reset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en_q <= 1'b0;
      ptv_q    <= '0;
      load_q   <= '0;
      ifc_q    <= 1'b0;
    end else begin
      if (hit[SLOT_CTRL]) begin
        pre_en_q <= bus_wdata[PRE_BIT];
        ptv_q    <= bus_wdata[PRE_BIT-1:PTV_LSB];
      end
      if (hit[SLOT_LOAD]) load_q <= bus_wdata;
      if (bus_we && (bus_addr == ADDR_W'(A_IFC))) ifc_q <= bus_wdata[0];
    end
  end

  always_comb begin
    busy_word    = '0;
    busy_word[0] = busy[SLOT_CTRL];
    busy_word[2] = busy[SLOT_LOAD];
    busy_word[3] = busy[SLOT_TRIG];
    busy_word[4] = busy[SLOT_KEY];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(A_CTRL): begin
        bus_rdata[PRE_BIT]              = pre_en_q;
        bus_rdata[PRE_BIT-1:PTV_LSB]    = ptv_q;
      end
      ADDR_W'(A_LOAD): bus_rdata    = load_q;
      ADDR_W'(A_CNT):  bus_rdata    = cnt_q;
      ADDR_W'(A_KEY):  bus_rdata[0] = run_q;
      ADDR_W'(A_BUSY): bus_rdata    = busy_word;
      ADDR_W'(A_IFC):  bus_rdata[0] = ifc_q;
      default:         bus_rdata    = '0;
    endcase
  end
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              wdt_reset,
  input logic              run_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] busy_word
);
  logic key_wr, trig_wr, load_busy_wr;
  assign key_wr       = bus_we && (bus_addr == ADDR_W'(A_KEY))  && !busy_word[4];
  assign trig_wr      = bus_we && (bus_addr == ADDR_W'(A_TRIG)) && !busy_word[3];
  assign load_busy_wr = bus_we && (bus_addr == ADDR_W'(A_LOAD)) &&  busy_word[2];

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (cnt_q == $past(load_q)));

  a_r10_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !trig_wr) |=> $stable(cnt_q));

  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy_wr |=> $stable(load_q));

  a_r2_start_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(key_wr && (bus_wdata[15:0] == KEY_RUN2)));

  a_r3_stop_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(key_wr && (bus_wdata[15:0] == KEY_HALT2)));
endmodule

bind wdg_keyed_top wdg_keyed_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .wdt_reset(wdt_reset), .run_q(run_q), .cnt_q(cnt_q),
  .load_q(load_q), .busy_word(busy_word)
);

// File: tb/wdg_keyed_top_test.sv
module wdg_keyed_top_test;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2;
  localparam int NV = 48;
  localparam int VW = 2 + 3 + 32 + 32 + 4;

  function automatic logic [VW-1:0] mk(logic [1:0] op, logic [2:0] a,
                                        logic [31:0] d, logic [31:0] e, logic [3:0] r);
    return {op, a, d, e, r};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mk(OP_R, 3'd0, 0, 0, 1),            // R1 control
    mk(OP_R, 3'd1, 0, 0, 1),            // R1 load
    mk(OP_R, 3'd2, 0, 0, 1),            // R1 counter
    mk(OP_R, 3'd5, 0, 0, 1),            // R1 busy
    mk(OP_R, 3'd4, 0, 0, 1),            // R1 stopped
    mk(OP_W, 3'd1, 100, 0, 0),
    mk(OP_R, 3'd5, 0, 32'h4, 8),        // R8 load busy bit 2
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_R, 3'd5, 0, 0, 8),            // R8 cleared after 2 ticks
    mk(OP_W, 3'd3, 0, 0, 0),
    mk(OP_R, 3'd2, 0, 100, 5),          // R5 reload
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_R, 3'd2, 0, 100, 10),         // R10 held while stopped
    mk(OP_W, 3'd4, 32'hBBBB, 0, 0),
    mk(OP_R, 3'd4, 0, 0, 2),            // R2 one word not enough
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_W, 3'd4, 32'h4444, 0, 0),
    mk(OP_R, 3'd4, 0, 1, 2),            // R2 running
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_R, 3'd2, 0, 102, 6),          // R6 one per tick
    mk(OP_W, 3'd4, 32'hAAAA, 0, 0),
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_W, 3'd4, 32'h1234, 0, 0),
    mk(OP_R, 3'd4, 0, 1, 4),            // R4 abandoned stop
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_W, 3'd4, 32'h5555, 0, 0),
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_R, 3'd4, 0, 1, 4),            // R4 orphan partner ignored
    mk(OP_R, 3'd2, 0, 108, 4),          // R4 still counting
    mk(OP_W, 3'd4, 32'hAAAA, 0, 0),
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_W, 3'd4, 32'h5555, 0, 0),
    mk(OP_R, 3'd4, 0, 0, 3),            // R3 stopped
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_R, 3'd2, 0, 110, 3),          // R3 counter holds
    mk(OP_W, 3'd0, 32'h24, 0, 0),
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_R, 3'd0, 0, 32'h24, 9),       // R9 control readback
    mk(OP_W, 3'd4, 32'hBBBB, 0, 0),
    mk(OP_T, 3'd0, 2, 0, 0),
    mk(OP_W, 3'd4, 32'h4444, 0, 0),
    mk(OP_T, 3'd0, 4, 0, 0),
    mk(OP_R, 3'd2, 0, 112, 6),          // R6 every 2 ticks with P=1
    mk(OP_W, 3'd3, 0, 0, 0),
    mk(OP_T, 3'd0, 3, 0, 0),
    mk(OP_R, 3'd2, 0, 101, 5),          // R5 phase cleared by trigger
    mk(OP_W, 3'd6, 32'hFFFF_FFFF, 0, 0),
    mk(OP_R, 3'd6, 0, 1, 9)             // R9 config bit 0 only
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          wdt_reset;
  int            n_chk = 0;
  int            n_bad = 0;
  int            cyc = 0;

  always #5 clk = ~clk;

  wdg_keyed_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .wdt_reset(wdt_reset)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 idle pulse", {31'b0, wdt_reset}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      case (v[VW-1 -: 2])
        OP_W: wr(v[VW-3 -: 3], v[67:36]);
        OP_T: ticks(int'(v[67:36]));
        default: rd_check(v[VW-3 -: 3], v[35:4], $sformatf("R%0d", v[3:0]));
      endcase
    end

    // R8: second load write while busy is dropped
    wr(3'd1, 200);
    wr(3'd1, 300);
    rd_check(3'd1, 200, "R8 busy write dropped");
    rd_check(3'd5, 32'h4, "R8 load busy");
    ticks(1);
    rd_check(3'd5, 32'h4, "R8 busy after one tick");
    ticks(1);
    rd_check(3'd5, 32'h0, "R8 busy clear");
    wr(3'd0, 0);
    rd_check(3'd5, 32'h1, "R8 control busy bit 0");
    ticks(2);

    // R7: overflow
    wr(3'd4, 32'hAAAA); ticks(2);
    wr(3'd4, 32'h5555); ticks(2);
    wr(3'd1, 32'hFFFF_FFFD); ticks(2);
    wr(3'd3, 0); ticks(2);
    rd_check(3'd2, 32'hFFFF_FFFD, "R5 reload near top");
    wr(3'd4, 32'hBBBB); ticks(2);
    wr(3'd4, 32'h4444);
    ticks(2);
    rd_check(3'd2, 32'hFFFF_FFFF, "R6 at top");
    check("R7 no pulse before wrap", {31'b0, wdt_reset}, 0);
    ticks(1);
    check("R7 pulse on wrap", {31'b0, wdt_reset}, 1);
    #1;
    check("R7 counter reloaded", bus_rdata, 32'hFFFF_FFFD);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, wdt_reset}, 0);
    ticks(1);
    rd_check(3'd2, 32'hFFFF_FFFE, "R7 counting resumes");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule